// File: doc/BRIEF.md
# Four-Channel Interval Timer

The block holds four independent 32-bit up-counting timer channels behind a small register interface. Each channel advances only when its own tick-enable input pulses high. Typical tick rates are about 32.768 kHz, 1 kHz, 1 MHz and 1 MHz. Software drives a channel with command writes: start, stop, clear, mode select, interrupt mask and interrupt clear. It also programs a terminal count. Status, current count and terminal count can be read back.

A channel counts from zero. When a tick arrives while the count equals the terminal count, the channel raises its pending flag. In continuous mode the count then returns to zero and keeps running, so a terminal count of all ones gives a free-running 32-bit counter. In one-shot mode the channel stops at the terminal count and goes idle. Each channel has its own level interrupt line. A single global register carries a clock-request bit that is shared by all channels.

The bus is single-cycle. A write is taken on the rising clock edge when the write strobe is high. Read data is combinational from the address.

Top module: `quad_interval_timer`

## Requirements
- R1: Channel n decodes at byte address n*0x40. Within a window the offsets are: 0x00 clear, 0x04 start, 0x08 stop, 0x0C mode, 0x10 status, 0x14 current count, 0x18 terminal count, 0x1C interrupt mask, 0x20 interrupt clear. The global register is at 0x100.
- R2: Any write to the clear, start or stop offset performs that action, whatever the write data.
- R3: The count rises by one per tick only while the channel is enabled, judged by the enable state at that clock edge. The count of a disabled channel, or of a channel that gets no tick, does not change.
- R4: In continuous mode (mode bit 0 = 0), a tick while count equals terminal count sets pending and returns the count to 0, and the channel keeps running.
- R5: In one-shot mode (mode bit 0 = 1), a tick while count equals terminal count sets pending. The count holds at the terminal count and the channel disables itself.
- R6: Status bits [3:0] are 0x1 when idle and 0x2 when enabled. Bit 4 is enable, bit 5 is one-shot, bit 6 is interrupt mask and bit 7 is pending. After reset the status reads 0x01, the count reads 0 and the terminal count reads all ones.
- R7: A write to interrupt clear with data bit 7 = 1 clears pending. With bit 7 = 0 it has no effect.
- R8: The interrupt mask takes data bit 0. The interrupt line of a channel is high exactly when both pending and mask are set.
- R9: The clear command zeroes the count and pending. Terminal count, mode, enable and mask keep their values.
- R10: A terminal count write is readable at once and is used by the next tick's comparison.
- R11: Reads of unmapped addresses and of write-only offsets return 0.
- R12: Global register bit 0 is readable and writable, and it drives the clock-request output.
- R13: A terminal hit in the same cycle as an interrupt clear leaves pending set. A clear command in the same cycle as a tick leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | NUM_CH | Per-channel count-enable pulse |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Combinational read data |
| irq | output | NUM_CH | Per-channel level interrupt |
| clk_req | output | 1 | Global clock-request bit |

## Verification
A channel's terminal hit can land in the same clock cycle as a software command on that channel. Two such collisions matter: a hit together with an interrupt clear, and a tick together with a clear command.

The bench provokes each collision by driving the tick pulse and the bus write on the same falling edge. It judges the result from the interrupt line and the count read back afterwards. The hit must win over the interrupt clear, so the interrupt stays high. The clear command must win over the tick, so the count reads 0.

// File: rtl/qit_pkg.sv
package qit_pkg;

   localparam int WIN_LSB     = 6;
   localparam int GLOBAL_ADDR = 'h100;

   localparam logic [WIN_LSB-1:0] OFS_CLR   = 6'h00;
   localparam logic [WIN_LSB-1:0] OFS_START = 6'h04;
   localparam logic [WIN_LSB-1:0] OFS_STOP  = 6'h08;
   localparam logic [WIN_LSB-1:0] OFS_MODE  = 6'h0C;
   localparam logic [WIN_LSB-1:0] OFS_STAT  = 6'h10;
   localparam logic [WIN_LSB-1:0] OFS_CNT   = 6'h14;
   localparam logic [WIN_LSB-1:0] OFS_TERM  = 6'h18;
   localparam logic [WIN_LSB-1:0] OFS_MASK  = 6'h1C;
   localparam logic [WIN_LSB-1:0] OFS_ICLR  = 6'h20;

   localparam logic [3:0] ST_IDLE   = 4'h1;
   localparam logic [3:0] ST_ACTIVE = 4'h2;
   localparam int STB_EN   = 4;
   localparam int STB_OS   = 5;
   localparam int STB_MASK = 6;
   localparam int STB_PEND = 7;
   localparam int ICLR_BIT = 7;

   typedef struct packed {
      logic clr;
      logic start;
      logic stop;
      logic mode;
      logic mask;
      logic iclr;
      logic term;
   } chan_cmd_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_CNT,
      SEL_TERM,
      SEL_GLOB
   } rd_sel_e;

endpackage

// File: rtl/qit_decode.sv
module qit_decode
   import qit_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 9,
   parameter int CH_W   = 2
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        we,
   output chan_cmd_t [NUM_CH-1:0]      cmd,
   output logic                        glob_wr,
   output rd_sel_e                     rd_sel,
   output logic [CH_W-1:0]             rd_ch
);
   localparam int WIN_W = ADDR_W - WIN_LSB;

   logic [WIN_W-1:0]   win;
   logic [WIN_LSB-1:0] ofs;
   logic               in_win;
   logic               is_glob;

   assign win     = addr[ADDR_W-1:WIN_LSB];
   assign ofs     = addr[WIN_LSB-1:0];
   assign in_win  = (int'(win) < NUM_CH);
   assign is_glob = (addr == ADDR_W'(GLOBAL_ADDR));
   assign glob_wr = we && is_glob;
   assign rd_ch   = win[CH_W-1:0];

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         cmd[c] = '0;
         if (we && in_win && (int'(win) == c)) begin
            case (ofs)
               OFS_CLR:   cmd[c].clr   = 1'b1;
               OFS_START: cmd[c].start = 1'b1;
               OFS_STOP:  cmd[c].stop  = 1'b1;
               OFS_MODE:  cmd[c].mode  = 1'b1;
               OFS_MASK:  cmd[c].mask  = 1'b1;
               OFS_ICLR:  cmd[c].iclr  = 1'b1;
               OFS_TERM:  cmd[c].term  = 1'b1;
               default:   cmd[c]       = '0;
            endcase
         end
      end
   end

   always_comb begin
      rd_sel = SEL_NONE;
      if (is_glob) begin
         rd_sel = SEL_GLOB;
      end else if (in_win) begin
         case (ofs)
            OFS_STAT: rd_sel = SEL_STAT;
            OFS_CNT:  rd_sel = SEL_CNT;
            OFS_TERM: rd_sel = SEL_TERM;
            default:  rd_sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/qit_channel.sv
module qit_channel
   import qit_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  chan_cmd_t         cmd,
   input  logic [DATA_W-1:0] wdata,
   output logic [7:0]        status,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  term,
   output logic              irq
);
   logic             en_q, os_q, mask_q, pend_q;
   logic [CNT_W-1:0] cnt_q, term_q;
   logic             at_term, hit;

   assign at_term = (cnt_q == term_q);
   assign hit     = tick && en_q && at_term && !cmd.clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         os_q   <= 1'b0;
         mask_q <= 1'b0;
         pend_q <= 1'b0;
         cnt_q  <= '0;
         term_q <= '1;
      end else begin
         if (cmd.mode) os_q   <= wdata[0];
         if (cmd.mask) mask_q <= wdata[0];
         if (cmd.term) term_q <= wdata[CNT_W-1:0];

         if (cmd.stop)             en_q <= 1'b0;
         else if (cmd.start)       en_q <= 1'b1;
         else if (hit && os_q)     en_q <= 1'b0;

         if (cmd.clr)              cnt_q <= '0;
         else if (tick && en_q) begin
            if (at_term)           cnt_q <= os_q ? cnt_q : '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end

         if (cmd.clr)              pend_q <= 1'b0;
         else if (hit)             pend_q <= 1'b1;
         else if (cmd.iclr && wdata[ICLR_BIT]) pend_q <= 1'b0;
      end
   end

   assign status = {pend_q, mask_q, os_q, en_q, (en_q ? ST_ACTIVE : ST_IDLE)};
   assign count  = cnt_q;
   assign term   = term_q;
   assign irq    = pend_q && mask_q;

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cmd.clr) |=> (cnt_q == $past(cnt_q))); // R3
   AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en_q && !os_q && (cnt_q == term_q) && !cmd.clr) |=> (cnt_q == '0 && pend_q)); // R4
   AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en_q && os_q && (cnt_q == term_q) && !cmd.clr && !cmd.start) |=> (!en_q && pend_q && cnt_q == $past(cnt_q))); // R5
   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.clr |=> (cnt_q == '0 && !pend_q)); // R9
   AST_ICLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.iclr && wdata[ICLR_BIT] && !(tick && en_q && (cnt_q == term_q))) |=> !pend_q); // R7
   AST_HIT_BEATS_ICLR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.iclr && tick && en_q && (cnt_q == term_q) && !cmd.clr) |=> pend_q); // R13

endmodule

// File: rtl/qit_rdmux.sv
module qit_rdmux
   import qit_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int CH_W   = 2
) (
   input  rd_sel_e                       sel,
   input  logic [CH_W-1:0]               ch,
   input  logic [NUM_CH-1:0][7:0]        stat,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  term,
   input  logic                          glob,
   output logic [DATA_W-1:0]             rdata
);
   always_comb begin
      rdata = '0;
      case (sel)
         SEL_STAT: rdata = DATA_W'(stat[ch]);
         SEL_CNT:  rdata = DATA_W'(cnt[ch]);
         SEL_TERM: rdata = DATA_W'(term[ch]);
         SEL_GLOB: rdata = DATA_W'(glob);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
   import qit_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq,
   output logic              clk_req
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH * (1 << WIN_LSB) > GLOBAL_ADDR)
      $error("NUM_CH must fit below the global register");
   if (CNT_W < 2 || CNT_W > DATA_W)
      $error("CNT_W must lie between 2 and DATA_W");
   if (DATA_W < 8)
      $error("DATA_W must hold the status byte");
   if (ADDR_W < 9 || ADDR_W - WIN_LSB < CH_W)
      $error("ADDR_W too narrow for the map");

   chan_cmd_t [NUM_CH-1:0]        cmd;
   logic                          glob_wr;
   rd_sel_e                       rd_sel;
   logic [CH_W-1:0]               rd_ch;
   logic [NUM_CH-1:0][7:0]        ch_stat;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_term;
   logic                          req_q;

   qit_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
      .addr   (bus_addr),
      .we     (bus_we),
      .cmd    (cmd),
      .glob_wr(glob_wr),
      .rd_sel (rd_sel),
      .rd_ch  (rd_ch)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      qit_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (tick_en[g]),
         .cmd   (cmd[g]),
         .wdata (bus_wdata),
         .status(ch_stat[g]),
         .count (ch_cnt[g]),
         .term  (ch_term[g]),
         .irq   (irq[g])
      );

      AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
         irq[g] |-> (ch_stat[g][STB_PEND] && ch_stat[g][STB_MASK])); // R8
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       req_q <= 1'b0;
      else if (glob_wr) req_q <= bus_wdata[0];
   end
   assign clk_req = req_q;

   qit_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .CH_W(CH_W)) u_rd (
      .sel  (rd_sel),
      .ch   (rd_ch),
      .stat (ch_stat),
      .cnt  (ch_cnt),
      .term (ch_term),
      .glob (req_q),
      .rdata(bus_rdata)
   );

   AST_REQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      glob_wr |=> (clk_req == $past(bus_wdata[0]))); // R12

endmodule

// File: tb/quad_interval_timer_tb.sv
module quad_interval_timer_tb;
   localparam int CLK_P = 10;
   localparam int NCH   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tick_en = '0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;
   logic        clk_req;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   quad_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
      .irq(irq), .clk_req(clk_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic tick(input int ch, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tick_en[ch] = 1'b1;
         @(negedge clk);
         tick_en[ch] = 1'b0;
      end
   endtask

   task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic irq_chk(input string req, input logic [3:0] exp);
      @(negedge clk);
      #1 chk(req, {28'd0, irq}, {28'd0, exp});
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [8:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R6, R12)
      for (int c = 0; c < NCH; c++) begin
         b = 9'(c * 64);
         rd_chk("R6 reset status", b + 9'h10, 32'h01);
         rd_chk("R6 reset count", b + 9'h14, 32'h0);
         rd_chk("R6 reset term", b + 9'h18, 32'hFFFF_FFFF);
      end
      irq_chk("R8 reset irq", 4'h0);
      chk("R12 reset clk_req", {31'd0, clk_req}, 32'd0);

      // continuous sweep over channels and terminal counts (R1 R2 R3 R4 R7 R8)
      for (int c = 0; c < NCH; c++) begin
         for (int t = 0; t < 4; t++) begin
            b = 9'(c * 64);
            wr(b + 9'h18, t);
            wr(b + 9'h0C, 32'h0);
            wr(b + 9'h1C, 32'h1);
            wr(b + 9'h00, 32'h1234_5678);
            wr(b + 9'h04, 32'hDEAD_BEEF);
            rd_chk("R2 R6 running status", b + 9'h10, 32'h52);
            tick(c, t);
            rd_chk("R1 R3 count at term", b + 9'h14, t);
            irq_chk("R4 no early irq", 4'h0);
            tick(c, 1);
            rd_chk("R4 wrap to zero", b + 9'h14, 32'h0);
            irq_chk("R4 R8 irq after hit", 4'(1 << c));
            rd_chk("R6 pending status", b + 9'h10, 32'hD2);
            wr(b + 9'h20, 32'h7F);
            irq_chk("R7 no clear without bit7", 4'(1 << c));
            wr(b + 9'h20, 32'h80);
            irq_chk("R7 clear with bit7", 4'h0);
            wr(b + 9'h08, 32'h0);
            tick(c, 3);
            rd_chk("R3 disabled holds", b + 9'h14, 32'h0);
         end
      end

      // tick on another channel leaves channel 2 unchanged (R3)
      wr(9'h080, 0); wr(9'h084, 0);
      tick(2, 2);
      tick(0, 3);
      rd_chk("R3 other tick no effect", 9'h094, 32'h2);
      wr(9'h088, 0);

      // one-shot (R5 R9 R10)
      for (int c = 0; c < NCH; c++) begin
         b = 9'(c * 64);
         wr(b + 9'h18, 32'h3);
         wr(b + 9'h0C, 32'h1);
         wr(b + 9'h00, 32'h0);
         wr(b + 9'h04, 32'h0);
         tick(c, 4);
         rd_chk("R5 count held", b + 9'h14, 32'h3);
         rd_chk("R5 R6 oneshot status", b + 9'h10, 32'hE1);
         irq_chk("R5 oneshot irq", 4'(1 << c));
         tick(c, 2);
         rd_chk("R5 stays stopped", b + 9'h14, 32'h3);
         wr(b + 9'h00, 32'hFFFF_FFFF);
         rd_chk("R9 clear count", b + 9'h14, 32'h0);
         rd_chk("R9 clear keeps mode/mask", b + 9'h10, 32'h61);
         rd_chk("R9 R10 term kept", b + 9'h18, 32'h3);
         irq_chk("R9 irq dropped", 4'h0);
      end

      // terminal rewrite mid-run (R10) and mask (R8)
      wr(9'h018, 32'd10); wr(9'h00C, 0); wr(9'h000, 0); wr(9'h004, 0);
      tick(0, 4);
      wr(9'h018, 32'd5);
      tick(0, 1);
      rd_chk("R10 count before new term", 9'h014, 32'd5);
      irq_chk("R10 no hit yet", 4'h0);
      tick(0, 1);
      rd_chk("R10 wrap at new term", 9'h014, 32'd0);
      irq_chk("R10 hit at new term", 4'h1);
      wr(9'h01C, 32'hFFFF_FFFE);
      irq_chk("R8 masked irq", 4'h0);
      rd_chk("R8 pending kept", 9'h010, 32'h92);
      wr(9'h01C, 32'h1);
      irq_chk("R8 unmasked irq", 4'h1);
      wr(9'h008, 0); wr(9'h020, 32'h80);

      // same-cycle collisions (R13)
      wr(9'h058, 32'd2); wr(9'h04C, 0); wr(9'h05C, 1); wr(9'h040, 0); wr(9'h044, 0);
      tick(1, 2);
      @(negedge clk);
      tick_en[1] = 1'b1; bus_addr = 9'h060; bus_wdata = 32'h80; bus_we = 1'b1;
      @(negedge clk);
      tick_en[1] = 1'b0; bus_we = 1'b0;
      irq_chk("R13 hit beats iclr", 4'h2);
      rd_chk("R13 count wrapped", 9'h054, 32'h0);
      tick(1, 1);
      @(negedge clk);
      tick_en[1] = 1'b1; bus_addr = 9'h040; bus_wdata = 32'h0; bus_we = 1'b1;
      @(negedge clk);
      tick_en[1] = 1'b0; bus_we = 1'b0;
      rd_chk("R13 clear beats tick", 9'h054, 32'h0);
      irq_chk("R13 clear drops pending", 4'h0);
      wr(9'h048, 0);

      // free-running default terminal (R4)
      wr(9'h0C0, 0); wr(9'h0D8, 32'hFFFF_FFFF); wr(9'h0CC, 0); wr(9'h0C4, 0);
      tick(3, 5);
      rd_chk("R4 free running", 9'h0D4, 32'd5);
      wr(9'h0C8, 0);

      // unmapped and write-only reads (R11)
      rd_chk("R11 clear offset", 9'h000, 0);
      rd_chk("R11 start offset", 9'h044, 0);
      rd_chk("R11 stop offset", 9'h088, 0);
      rd_chk("R11 mode offset", 9'h0CC, 0);
      rd_chk("R11 mask offset", 9'h01C, 0);
      rd_chk("R11 iclr offset", 9'h060, 0);
      rd_chk("R11 gap 0x24", 9'h024, 0);
      rd_chk("R11 gap 0x3C", 9'h03C, 0);
      rd_chk("R11 above global", 9'h104, 0);
      rd_chk("R11 top", 9'h1FC, 0);

      // global clock request (R12)
      rd_chk("R12 read zero", 9'h100, 0);
      wr(9'h100, 32'h1);
      rd_chk("R12 read one", 9'h100, 1);
      chk("R12 output high", {31'd0, clk_req}, 32'd1);
      wr(9'h100, 32'hFFFF_FFFE);
      chk("R12 output low", {31'd0, clk_req}, 32'd0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule